// File: doc/BRIEF.md
# Bit-Parallel Stuck-At Fault Simulator

This block evaluates one small, fixed combinational netlist for a whole group of circuit copies at once. Every net is a word with one bit per copy. Lane 0 is the fault-free circuit. Each higher lane is a copy of the circuit with exactly one single stuck-at fault in it. The three primary-input bits are copied into every lane. Each faulted net then has its faulty lane forced to the stuck level, and every gate downstream in that lane sees the forced value. Logic is two-valued and gate delays are zero.

A pulse on `start` captures the per-lane output word and a detection mask. A lane is detected when its output differs from the fault-free lane. A sticky coverage register ORs each pattern's detection mask into a running total, so a sequence of patterns builds up fault coverage. A synchronous `clear` input empties that total.

The netlist has three inputs P, Q and R. Q is a stem with two branches. Its gates are: NAND of P and the first branch; an inverter on the second branch; an AND of that inverter with R; and a final OR of the NAND and the AND, which drives the single primary output. The fault list has three entries, one per lane: output stuck-at-0 in lane 1, stem Q stuck-at-1 in lane 2, and input R stuck-at-0 in lane 3.

Top module: `pfs_sim`

## Requirements
- R1: While `rst` is high at a clock edge, `po_word`, `det_mask` and `cum_mask` become 0 and `done` becomes 0.
- R2: The word is 4 lanes wide. Lane 0 is fault-free, lane 1 has the primary output stuck-at-0, lane 2 has stem Q stuck-at-1 (both branches see 1), and lane 3 has input R stuck-at-0. Input bits are copied into all lanes before any forcing.
- R3: `pi[2]` is P, `pi[1]` is Q and `pi[0]` is R. The fault-free output is NAND(P,Q) OR (NOT Q AND R). `po_word[i]` is the output of lane i.
- R4: `det_mask[i]` is `po_word[i]` XOR `po_word[0]`, so bit 0 is always 0.
- R5: The pattern on `pi` is captured at the clock edge where `start` is high, and the results appear right after that edge. `done` rises at that edge and then stays high until reset.
- R6: While `start` is low, changes on `pi` have no effect on `po_word`, `det_mask` or `done`.
- R7: At each start, `cum_mask` becomes its previous value ORed with the new detection mask.
- R8: `clear` high with `start` low sets `cum_mask` to 0 at that edge.
- R9: When `clear` and `start` are high at the same edge, `cum_mask` becomes exactly the new detection mask, with no earlier coverage kept.
- R10: The lane 3 fault is redundant in this netlist, so applying all eight patterns gives a coverage of 4'b0110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Evaluate the pattern on `pi` at this edge |
| clear | input | 1 | Synchronous clear of the coverage register |
| pi | input | 3 | Primary-input pattern {P,Q,R} |
| po_word | output | 4 | Primary output of each lane |
| det_mask | output | 4 | Lanes whose output differs from lane 0 |
| cum_mask | output | 4 | Sticky OR of detection masks since the last clear |
| done | output | 1 | High once a pattern has been evaluated |

## Verification
Clearing coverage and accumulating a new pattern can happen at the same edge. The bench provokes this by raising `clear` and `start` together, twice. The first time, the earlier coverage is 4'b0110 and the new pattern detects the same lanes. The second time, the new pattern detects only lane 1. The expected coverage after each edge is the new mask alone, never the union with the older total. A clear with `start` low is also applied on its own, to separate the two cases.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [3:0] {
    NET_P, NET_Q, NET_R, NET_QU, NET_QV,
    NET_NAND, NET_INV, NET_AND, NET_OUT
  } net_e;

  typedef struct packed {
    net_e site;
    logic level;
  } fault_t;

  localparam int NUM_FAULTS = 3;
  localparam int LANES      = NUM_FAULTS + 1;
  localparam int PI_W       = 3;

  // lane k+1 carries FAULT_LIST[k]
  localparam fault_t FAULT_LIST [NUM_FAULTS] = '{
    '{site: NET_OUT, level: 1'b0},
    '{site: NET_Q,   level: 1'b1},
    '{site: NET_R,   level: 1'b0}
  };

  function automatic logic [LANES-1:0] stuck_mask(net_e n, logic lvl);
    logic [LANES-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_FAULTS; k++) begin
      if (FAULT_LIST[k].site == n && FAULT_LIST[k].level == lvl)
        m[k+1] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pfs_force.sv
module pfs_force
  import pfs_pkg::*;
#(
  parameter net_e SITE = NET_P
) (
  input  logic [LANES-1:0] raw,
  output logic [LANES-1:0] forced
);

  localparam logic [LANES-1:0] CLR_M = stuck_mask(SITE, 1'b0);
  localparam logic [LANES-1:0] SET_M = stuck_mask(SITE, 1'b1);

  assign forced = (raw & ~CLR_M) | SET_M;

  always_comb begin
    if (!$isunknown(raw))
      assert_lane0_untouched_R2: assert (forced[0] == raw[0]);
  end

endmodule

// File: rtl/pfs_netlist.sv
module pfs_netlist
  import pfs_pkg::*;
(
  input  logic [PI_W-1:0]  pi,
  output logic [LANES-1:0] out_word
);

  logic [LANES-1:0] p_raw, q_raw, r_raw;
  logic [LANES-1:0] p_w, q_w, r_w, qu_w, qv_w;
  logic [LANES-1:0] nand_raw, inv_raw, and_raw, out_raw;
  logic [LANES-1:0] nand_w, inv_w, and_w;

  // replicate each primary input into every lane
  for (genvar gl = 0; gl < LANES; gl++) begin : g_bcast
    assign p_raw[gl] = pi[2];
    assign q_raw[gl] = pi[1];
    assign r_raw[gl] = pi[0];
  end

  pfs_force #(.SITE(NET_P))    u_fp  (.raw(p_raw),    .forced(p_w));
  pfs_force #(.SITE(NET_Q))    u_fq  (.raw(q_raw),    .forced(q_w));
  pfs_force #(.SITE(NET_R))    u_fr  (.raw(r_raw),    .forced(r_w));
  pfs_force #(.SITE(NET_QU))   u_fqu (.raw(q_w),      .forced(qu_w));
  pfs_force #(.SITE(NET_QV))   u_fqv (.raw(q_w),      .forced(qv_w));

  assign nand_raw = ~(p_w & qu_w);
  assign inv_raw  = ~qv_w;
  pfs_force #(.SITE(NET_NAND)) u_fn  (.raw(nand_raw), .forced(nand_w));
  pfs_force #(.SITE(NET_INV))  u_fi  (.raw(inv_raw),  .forced(inv_w));

  assign and_raw = inv_w & r_w;
  pfs_force #(.SITE(NET_AND))  u_fa  (.raw(and_raw),  .forced(and_w));

  assign out_raw = nand_w | and_w;
  pfs_force #(.SITE(NET_OUT))  u_fo  (.raw(out_raw),  .forced(out_word));

endmodule

// File: rtl/pfs_lane_cmp.sv
module pfs_lane_cmp
  import pfs_pkg::*;
(
  input  logic [LANES-1:0] word,
  output logic [LANES-1:0] diff
);

  for (genvar gl = 0; gl < LANES; gl++) begin : g_cmp
    assign diff[gl] = word[gl] ^ word[0];
  end

endmodule

// File: rtl/pfs_sim.sv
module pfs_sim
  import pfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             clear,
  input  logic [PI_W-1:0]  pi,
  output logic [LANES-1:0] po_word,
  output logic [LANES-1:0] det_mask,
  output logic [LANES-1:0] cum_mask,
  output logic             done
);

  logic [LANES-1:0] eval_word;
  logic [LANES-1:0] eval_diff;

  pfs_netlist  u_net (.pi(pi), .out_word(eval_word));
  pfs_lane_cmp u_cmp (.word(eval_word), .diff(eval_diff));

  always_ff @(posedge clk) begin
    if (rst) begin
      po_word  <= '0;
      det_mask <= '0;
      cum_mask <= '0;
      done     <= 1'b0;
    end else if (start) begin
      po_word  <= eval_word;
      det_mask <= eval_diff;
      cum_mask <= (clear ? '0 : cum_mask) | eval_diff;
      done     <= 1'b1;
    end else if (clear) begin
      cum_mask <= '0;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (po_word == '0 && det_mask == '0 && cum_mask == '0 && !done));

  assert_lane0_clean_R4: assert property (@(posedge clk) disable iff (rst)
    !det_mask[0]);

  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(po_word) && $stable(det_mask) && $stable(done)));

  assert_cum_covers_R7: assert property (@(posedge clk) disable iff (rst)
    start |=> ((cum_mask & det_mask) == det_mask));

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clear && !start) |=> (cum_mask == '0));

  assert_clear_start_R9: assert property (@(posedge clk) disable iff (rst)
    (clear && start) |=> (cum_mask == det_mask));

endmodule

// File: tb/pfs_sim_bench.sv
module pfs_sim_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          clear = 1'b0;
  logic [2:0]    pi = '0;
  logic [NL-1:0] po_word, det_mask, cum_mask;
  logic          done;

  pfs_sim u_pfs_sim (
    .clk(clk), .rst(rst), .start(start), .clear(clear), .pi(pi),
    .po_word(po_word), .det_mask(det_mask), .cum_mask(cum_mask), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [NL-1:0] po;
    logic [NL-1:0] det;
    logic [NL-1:0] cum;
    logic          dn;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   finished = 0;

  logic [NL-1:0] m_po = '0, m_det = '0, m_cum = '0;
  logic          m_dn = 1'b0;

  // lanes per R2/R3: {stuck R=0, stem Q=1, output=0, fault-free}
  function automatic logic [NL-1:0] exp_po(logic [2:0] v);
    logic a, b, f;
    a = v[2]; b = v[1]; f = v[0];
    return { ~(a & b) | (~b & 1'b0),
             ~(a & 1'b1) | (1'b0 & f),
             1'b0,
             ~(a & b) | (~b & f) };
  endfunction

  task automatic push_expect(string tag);
    exp_t e;
    e.po = m_po; e.det = m_det; e.cum = m_cum; e.dn = m_dn; e.tag = tag;
    exp_q.push_back(e);
    ->chk_ev;
  endtask

  task automatic apply(logic [2:0] v, logic st, logic cl, string tag);
    @(negedge clk);
    pi = v; start = st; clear = cl;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; clear = 1'b0;
    if (st) begin
      m_po  = exp_po(v);
      m_det = m_po ^ {NL{m_po[0]}};
      m_cum = (cl ? '0 : m_cum) | m_det;
      m_dn  = 1'b1;
    end else if (cl) begin
      m_cum = '0;
    end
    push_expect(tag);
    #1;
  endtask

  // monitor: pop and compare
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        bit bad;
        e = exp_q.pop_front();
        bad = 0;
        n_vec++;
        if (po_word !== e.po) begin
          $display("FAIL %s po_word act %h exp %h", e.tag, po_word, e.po); bad = 1;
        end
        if (det_mask !== e.det) begin
          $display("FAIL %s det_mask act %h exp %h", e.tag, det_mask, e.det); bad = 1;
        end
        if (cum_mask !== e.cum) begin
          $display("FAIL %s cum_mask act %h exp %h", e.tag, cum_mask, e.cum); bad = 1;
        end
        if (done !== e.dn) begin
          $display("FAIL %s done act %b exp %b", e.tag, done, e.dn); bad = 1;
        end
        if (bad) n_fail++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog act hung exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    push_expect("R1 reset state");
    #1;

    // all eight patterns (R2 R3 R4 R5 R7)
    for (int k = 0; k < 8; k++)
      apply(k[2:0], 1'b1, 1'b0, "R2/R3/R4/R5/R7 pattern sweep");

    // R10: lane 3 never detected, total 0110
    if (cum_mask !== 4'b0110) begin
      $display("FAIL R10 coverage act %h exp %h", cum_mask, 4'b0110);
      n_fail++;
    end
    n_vec++;

    // R6: pattern change without start leaves results untouched
    apply(3'b100, 1'b0, 1'b0, "R6 hold without start");
    apply(3'b001, 1'b0, 1'b0, "R6 hold without start");

    // R8: clear alone
    apply(3'b101, 1'b0, 1'b1, "R8 clear alone");

    apply(3'b100, 1'b1, 1'b0, "R7 accumulate");
    // R9: clear and start together
    apply(3'b101, 1'b1, 1'b1, "R9 clear with start");
    apply(3'b000, 1'b1, 1'b1, "R9 clear with start");
    apply(3'b110, 1'b1, 1'b0, "R7 no new detection");
    apply(3'b100, 1'b1, 1'b0, "R7 accumulate again");

    // reset mid-run returns everything to zero
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_po = '0; m_det = '0; m_cum = '0; m_dn = 1'b0;
    push_expect("R1 reset after activity");
    #1;

    repeat (2) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule